// File: doc/BRIEF.md
# ARINC 429 Sampling Bit Receiver

This block turns a stream of line-state samples from an external window comparator into complete 32-bit ARINC 429 words. Each sample is one of four codes: one, zero, null, or between-band. The block takes ten samples per nominal bit. In high-speed mode it samples on every clock. In low-speed mode it samples on every eighth clock. It keeps a ten-sample history for each of the one, zero and null states, and it decides from short runs in those histories whether a genuine bit has been seen. It also checks the pulse-to-pulse spacing of consecutive bits.

A finished word is presented on `word_out` together with a one-cycle `word_valid` strobe. ARINC bit 1, the first bit on the line, lands in bit 0. When odd parity checking is on, bit 31 becomes a parity-status bit. Any malformed bit or spacing error throws the partial word away. After a word ends, or after a word is rejected, the receiver stays deaf until it has seen a proper inter-word gap. The same deaf period applies after reset.

Top module: `a429_bit_rx`

## Requirements
- R1: `line_state` codes are 2'b00 null, 2'b01 one, 2'b10 zero and 2'b11 between-band. A sample enters at most one of the three histories, and a between-band sample enters none. A bit whose trailing null samples are between-band is therefore not recognised, and its word is discarded.
- R2: A bit is recognised when two conditions hold together. The five oldest samples of the one history (or of the zero history) must contain three consecutive hits. The five newest samples of the null history must also contain three consecutive hits. A pulse only two samples wide is not a bit, and its word is discarded.
- R3: The n-th recognised bit of a word appears at `word_out[n-1]`. A word is emitted only after 32 bits have been recognised.
- R4: The spacing between consecutive recognised bits, counted in samples, must be 8 to 12 inclusive. A spacing of 7, or a spacing of 13 or more, discards the word.
- R5: After reset, after each emitted word and after each rejection, reception is re-armed only after three null-gap checks have passed. The checks are taken every 10 samples. A check passes when both halves of the null history hold a run of three nulls. A word that begins before re-arming is dropped entirely.
- R6: With `parity_en`=1, `word_out[31]` is 0 when the count of ones over all 32 received bits is odd, and 1 when it is even. With `parity_en`=0, all 32 bits are passed unchanged.
- R7: `word_valid` is a single-cycle pulse. `word_out` changes only with that pulse, and otherwise keeps the last word. Both are 0 after reset.
- R8: `rate_slow`=0 takes one sample per clock. `rate_slow`=1 takes one sample every 8 clocks. A word sent at either rate is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_slow | input | 1 | 1 selects the low-speed sample rate |
| parity_en | input | 1 | 1 enables odd-parity reporting in bit 31 |
| line_state | input | 2 | Comparator output code for the current sample |
| word_out | output | 32 | Last received word, bit 0 is first ARINC bit |
| word_valid | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The assertions assume that `line_state` holds a legal code through each sample period. They also assume that `rate_slow` and `parity_en` change only while the line is null between words. The bench honours this by holding every sample for exactly one sample period at the selected rate, and by switching the controls only during gap stretches. Every word is followed by at least five null bit-times. The only exception is the deliberately short gap that tests R5. As a result, an illegal pattern is always one the bench chose to inject: a narrow pulse, between-band nulls, off-nominal spacing or a short gap.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam logic [1:0] LS_NULL = 2'b00;
    localparam logic [1:0] LS_ONE  = 2'b01;
    localparam logic [1:0] LS_ZERO = 2'b10;
    localparam logic [1:0] LS_BAND = 2'b11;

    typedef enum logic [1:0] {
        RX_GAP  = 2'd0,
        RX_IDLE = 2'd1,
        RX_BUSY = 2'd2
    } rx_state_e;

endpackage

// File: rtl/a429_sample_tick.sv
module a429_sample_tick #(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_slow,
    output logic tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim   = rate_slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
        cnt_d = (cnt_q >= lim) ? '0 : cnt_q + CW'(1);
        tick  = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/a429_state_hist.sv
module a429_state_hist
    import a429_rx_pkg::*;
#(
    parameter int HIST_LEN = 10,
    parameter int RUN      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] line_state,
    output logic       one_up,
    output logic       zero_up,
    output logic       null_up,
    output logic       null_lo,
    output logic       fresh,
    output logic [2:0] newest
);
    localparam int HALF = HIST_LEN / 2;

    function automatic logic run_of(input logic [HALF-1:0] v);
        logic r;
        r = 1'b0;
        for (int i = 0; i <= HALF - RUN; i++) r = r | (&v[i +: RUN]);
        return r;
    endfunction

    logic [2:0]          hit;
    logic [HIST_LEN-1:0] hist_d [3];
    logic [HIST_LEN-1:0] hist_q [3];
    logic [2:0]          up_run, lo_run;
    logic                fresh_d, fresh_q;

    // index 0: one, 1: zero, 2: null; between-band hits none
    assign hit[0] = (line_state == LS_ONE);
    assign hit[1] = (line_state == LS_ZERO);
    assign hit[2] = (line_state == LS_NULL);
    assign fresh_d = tick;

    for (genvar k = 0; k < 3; k++) begin : g_hist
        always_comb begin
            hist_d[k] = tick ? {hist_q[k][HIST_LEN-2:0], hit[k]} : hist_q[k];
            up_run[k] = run_of(hist_q[k][HIST_LEN-1:HALF]);
            lo_run[k] = run_of(hist_q[k][HALF-1:0]);
        end
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[k] <= '0;
            else        hist_q[k] <= hist_d[k];
        end
        assign newest[k] = hist_q[k][0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= fresh_d;
    end

    assign one_up  = up_run[0];
    assign zero_up = up_run[1];
    assign null_up = up_run[2];
    assign null_lo = lo_run[2];
    assign fresh   = fresh_q;
    // lo_run[0], lo_run[1] only feed the run vector for symmetry
    logic unused_lo;
    assign unused_lo = lo_run[0] ^ lo_run[1];
endmodule

// File: rtl/a429_bit_rx.sv
module a429_bit_rx
    import a429_rx_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int HIST_LEN   = 10,
    parameter int RUN        = 3,
    parameter int SPACE_MIN  = 8,
    parameter int SPACE_MAX  = 12,
    parameter int GAP_PERIOD = 10,
    parameter int GAP_NEED   = 3,
    parameter int FAST_DIV   = 1,
    parameter int SLOW_DIV   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_slow,
    input  logic              parity_en,
    input  logic [1:0]        line_state,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    localparam int BC_W  = $clog2(WORD_W);
    localparam int SPC_W = $clog2(SPACE_MAX + 2);
    localparam int GT_W  = $clog2(GAP_PERIOD);
    localparam int GC_W  = $clog2(GAP_NEED + 1);

    typedef struct packed {
        rx_state_e         state;
        logic [BC_W-1:0]   bits;
        logic [SPC_W-1:0]  space;
        logic [GT_W-1:0]   gtmr;
        logic [GC_W-1:0]   gcnt;
        logic [WORD_W-1:0] shreg;
        logic              par;
        logic              cond;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic tick, fresh, one_up, zero_up, null_up, null_lo;
    logic [2:0] hist_newest;
    logic bit_cond, det, gap_null, last_bit;
    logic [SPC_W-1:0] space_n;

    a429_sample_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .tick(tick)
    );

    a429_state_hist #(.HIST_LEN(HIST_LEN), .RUN(RUN)) u_hist (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state),
        .one_up(one_up), .zero_up(zero_up), .null_up(null_up),
        .null_lo(null_lo), .fresh(fresh), .newest(hist_newest)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        bit_cond  = (one_up | zero_up) & null_lo;
        det       = bit_cond & ~r_q.cond;
        gap_null  = null_up & null_lo;
        space_n   = (r_q.space == '1) ? r_q.space : r_q.space + SPC_W'(1);
        last_bit  = parity_en ? ~(r_q.par ^ one_up) : one_up;
        if (fresh) begin
            r_d.cond = bit_cond;
            unique case (r_q.state)
                RX_GAP: begin
                    if (r_q.gtmr == GT_W'(GAP_PERIOD - 1)) begin
                        r_d.gtmr = '0;
                        if (gap_null) begin
                            if (r_q.gcnt == GC_W'(GAP_NEED - 1)) begin
                                r_d.state = RX_IDLE;
                                r_d.gcnt  = '0;
                            end else begin
                                r_d.gcnt = r_q.gcnt + GC_W'(1);
                            end
                        end
                    end else begin
                        r_d.gtmr = r_q.gtmr + GT_W'(1);
                    end
                end
                RX_IDLE: begin
                    if (det) begin
                        r_d.state = RX_BUSY;
                        r_d.shreg = {one_up, {(WORD_W-1){1'b0}}};
                        r_d.par   = one_up;
                        r_d.bits  = BC_W'(1);
                        r_d.space = '0;
                    end
                end
                default: begin
                    if ((det && (space_n < SPC_W'(SPACE_MIN))) ||
                        (space_n > SPC_W'(SPACE_MAX))) begin
                        r_d.state = RX_GAP;
                        r_d.gtmr  = '0;
                        r_d.gcnt  = '0;
                    end else if (det) begin
                        r_d.space = '0;
                        if (r_q.bits == BC_W'(WORD_W - 1)) begin
                            r_d.word  = {last_bit, r_q.shreg[WORD_W-1:1]};
                            r_d.valid = 1'b1;
                            r_d.state = RX_GAP;
                            r_d.gtmr  = '0;
                            r_d.gcnt  = '0;
                        end else begin
                            r_d.shreg = {one_up, r_q.shreg[WORD_W-1:1]};
                            r_d.par   = r_q.par ^ one_up;
                            r_d.bits  = r_q.bits + BC_W'(1);
                        end
                    end else begin
                        r_d.space = space_n;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    rx_state_e        st_now;
    logic [BC_W-1:0]  bits_now;
    logic [SPC_W-1:0] space_now;
    assign st_now    = r_q.state;
    assign bits_now  = r_q.bits;
    assign space_now = r_q.space;

    assign word_out   = r_q.word;
    assign word_valid = r_q.valid;
endmodule

// File: rtl/a429_bit_rx_chk.sv
module a429_bit_rx_chk
    import a429_rx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BC_W      = 5,
    parameter int SPC_W     = 4,
    parameter int SPACE_MAX = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_out,
    input rx_state_e         state,
    input logic [BC_W-1:0]   bits,
    input logic [SPC_W-1:0]  space,
    input logic [2:0]        newest
);
    assert_one_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(newest));

    assert_bits_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY) |-> (bits >= BC_W'(1) && bits <= BC_W'(WORD_W - 1)));

    assert_valid_from_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(state) == RX_BUSY);

    assert_space_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY) |-> (space <= SPC_W'(SPACE_MAX)));

    assert_rx_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BUSY && $past(state) != RX_BUSY) |-> $past(state) == RX_IDLE);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out != $past(word_out)) |-> word_valid);
endmodule

bind a429_bit_rx a429_bit_rx_chk #(
    .WORD_W(WORD_W), .BC_W(BC_W), .SPC_W(SPC_W), .SPACE_MAX(SPACE_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_out(word_out),
    .state(st_now), .bits(bits_now), .space(space_now), .newest(hist_newest)
);

// File: tb/a429_bit_rx_tb.sv
module a429_bit_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_slow = 1'b0;
    logic        parity_en = 1'b0;
    logic [1:0]  line_state = 2'b00;
    logic [31:0] word_out;
    logic        word_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = 32'h0;
    logic        prev_valid = 1'b0;

    always #5 clk = ~clk;

    a429_bit_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .parity_en(parity_en),
        .line_state(line_state), .word_out(word_out), .word_valid(word_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected value from the requirements
    function automatic logic [31:0] model(input logic [31:0] d, input logic pe);
        if (pe) return {~(^d), d[30:0]};
        return d;
    endfunction

    task automatic expect_word(input logic [31:0] d, input string tag);
        last_exp = model(d, parity_en);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    task automatic put(input logic [1:0] s);
        line_state = s;
        repeat (rate_slow ? 8 : 1) @(negedge clk);
    endtask

    task automatic gap(input int nbits);
        repeat (nbits * 10) put(2'b00);
    endtask

    // kind 0: clean, 1: narrow pulse at bad_idx, 2: between-band nulls at bad_idx
    task automatic send_word(input logic [31:0] d, input int period, input int ones,
                             input int bad_idx, input int kind);
        for (int i = 0; i < 32; i++) begin
            logic [1:0] pc;
            pc = d[i] ? 2'b01 : 2'b10;
            for (int s = 0; s < period; s++) begin
                logic [1:0] st;
                st = (s < ones) ? pc : 2'b00;
                if (i == bad_idx && kind == 1) st = (s < 2) ? pc : 2'b00;
                if (i == bad_idx && kind == 2) st = (s < ones) ? pc : 2'b11;
                put(st);
            end
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid && prev_valid) begin
                checks++; fails++;
                $display("FAIL R7: actual valid high 2 cycles expected 1");
            end
            if (word_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3: actual unexpected word %h expected none", word_out);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, word_out, e);
                end
            end
        end
        prev_valid <= word_valid;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R7 reset valid", {31'b0, word_valid}, 32'h0);
        check("R7 reset word", word_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        gap(5);

        // R3 / R8 fast-rate clean words
        expect_word(32'hA5A5_0F3C, "R3"); send_word(32'hA5A5_0F3C, 10, 5, -1, 0); gap(5);
        expect_word(32'h0000_0001, "R3"); send_word(32'h0000_0001, 10, 5, -1, 0); gap(5);
        expect_word(32'hFFFF_FFFE, "R2"); send_word(32'hFFFF_FFFE, 10, 5, -1, 0); gap(5);
        expect_word(32'h8000_0000, "R8"); send_word(32'h8000_0000, 10, 5, -1, 0); gap(5);

        // R4 spacing limits
        expect_word(32'h1357_2468, "R4"); send_word(32'h1357_2468, 8, 4, -1, 0); gap(5);
        expect_word(32'h2468_ACE0, "R4"); send_word(32'h2468_ACE0, 12, 5, -1, 0); gap(5);
        send_word(32'h0F0F_0F0F, 7, 4, -1, 0); gap(5);
        check("R4 spacing 7 rejected", word_out, last_exp);
        send_word(32'h3C3C_3C3C, 13, 5, -1, 0); gap(5);
        check("R4 spacing 13 rejected", word_out, last_exp);

        // R2 narrow pulse, R1 between-band nulls
        send_word(32'h1111_2222, 10, 5, 4, 1); gap(5);
        check("R2 narrow pulse rejected", word_out, last_exp);
        send_word(32'h3333_4444, 10, 5, 9, 2); gap(5);
        check("R1 between-band rejected", word_out, last_exp);

        // R5 short gap drops the following word
        expect_word(32'h5555_AAAA, "R5"); send_word(32'h5555_AAAA, 10, 5, -1, 0); gap(1);
        send_word(32'h6666_9999, 10, 5, -1, 0); gap(5);
        check("R5 short-gap word dropped", word_out, last_exp);
        expect_word(32'h7777_8888, "R5"); send_word(32'h7777_8888, 10, 5, -1, 0); gap(5);

        // R6 parity
        parity_en = 1'b1;
        gap(1);
        expect_word(32'h0000_0001, "R6"); send_word(32'h0000_0001, 10, 5, -1, 0); gap(5);
        expect_word(32'h0000_0003, "R6"); send_word(32'h0000_0003, 10, 5, -1, 0); gap(5);
        expect_word(32'h8000_0003, "R6"); send_word(32'h8000_0003, 10, 5, -1, 0); gap(5);
        expect_word(32'h7FFF_FFFF, "R6"); send_word(32'h7FFF_FFFF, 10, 5, -1, 0); gap(5);
        parity_en = 1'b0;
        gap(1);
        expect_word(32'h8000_0003, "R6"); send_word(32'h8000_0003, 10, 5, -1, 0); gap(5);

        // R8 slow rate
        rate_slow = 1'b1;
        gap(5);
        expect_word(32'h5A5A_C3C3, "R8"); send_word(32'h5A5A_C3C3, 10, 5, -1, 0); gap(5);
        rate_slow = 1'b0;
        gap(2);

        check("R3 all expected words seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule